// File: doc/BRIEF.md
# Host/Local Mailbox Register Block with Pending Interrupts

This block lets a local requester pass 32-bit messages to a host requester through eight outbound mailbox words. Both requesters share one clock and reach the block through their own simple memory-mapped ports. Each port has its own address window. The local side can only write the mailboxes, and the host side can only read them.

Every local mailbox write latches a pending flag for that mailbox in a host-visible status word. The host clears a flag by writing a one to its bit position. A host enable word selects which pending flags may raise a level-sensitive interrupt toward the host. The interrupt is registered, so it follows the masked pending state with one cycle of delay.

Top module: `mbx_dual_port`

## Requirements
- R1: A local write to byte offset 0x3A00 + 4·n (n = 0..7, taken from address bits 4:2) stores the full 32-bit write data in mailbox n. A local write outside 0x3A00–0x3A1F changes no mailbox and no pending flag.
- R2: A host read of offset 0x0900 + 4·n returns mailbox n on `hst_rdata` in the cycle after the read strobe. A host write into 0x0900–0x091F changes no mailbox.
- R3: A local write to mailbox n sets status bit 16+n, so mailbox 7 sets bit 23 and mailbox 6 sets bit 22. Host reads status at offset 0x0040.
- R4: A host write to offset 0x0040 clears each status bit 23:16 whose write-data bit is 1. Bits written as 0 keep their value.
- R5: When a local write to mailbox n and a host clear of bit 16+n happen in the same cycle, bit 16+n ends up set.
- R6: Status bits 31:24 and 15:0 always read as zero.
- R7: A host write to offset 0x0050 loads enable bits 23:16 from write-data bits 23:16. A read of 0x0050 returns those bits, with all other bits zero.
- R8: `irq_out` is high in a cycle exactly when, one cycle earlier, some status bit 16+n and enable bit 16+n were both set. It is therefore low whenever the enables were all zero in the previous cycle.
- R9: A host read of any other offset returns zero. `hst_rdata` changes only on a host read strobe.
- R10: Synchronous reset clears all mailboxes, status bits, enable bits, `hst_rdata` and `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| loc_wr | input | 1 | Local write strobe, one cycle per write |
| loc_addr | input | 14 | Local byte address |
| loc_wdata | input | 32 | Local write data |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 14 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after `hst_rd` |
| irq_out | output | 1 | Level interrupt toward the host |

## Verification
The embedded properties check on every cycle the following: a local window write lands in the addressed mailbox, and mailboxes stay put when the local side is not writing its window. Any flag set in a cycle is present afterwards even if the host also clears it, and a host clear without a competing set leaves the bit at zero. The status read returns zeros in the reserved bits, and the interrupt stays low after a cycle with no enables. Only the bench scenarios can show the end-to-end paths and their timing. These are data travelling from the local window to the host window, the delay of the interrupt after a write and after a clear or an enable removal, zero data from undefined host offsets, and the state after a reset in the middle of a run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned ADDR_W   = 14;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned MBX_N    = 8;
    localparam int unsigned IDX_W    = $clog2(MBX_N);
    localparam int unsigned BYTE_W   = 2;             // byte offset bits in a word
    localparam int unsigned WIN_LSB  = IDX_W + BYTE_W; // low bits that index inside a window
    localparam int unsigned PEND_LSB = 16;            // mailbox n -> status bit PEND_LSB+n

    localparam logic [ADDR_W-1:0] LOC_MBX_BASE  = 14'h3A00;
    localparam logic [ADDR_W-1:0] HST_MBX_BASE  = 14'h0900;
    localparam logic [ADDR_W-1:0] HST_STAT_ADDR = 14'h0040;
    localparam logic [ADDR_W-1:0] HST_EN_ADDR   = 14'h0050;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [MBX_N-1:0]  pend_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        HSEL_NONE,
        HSEL_STAT,
        HSEL_EN,
        HSEL_MBX
    } hsel_e;

    typedef struct packed {
        hsel_e sel;
        idx_t  idx;
    } hdec_t;

    function automatic logic in_window(input addr_t a, input addr_t base);
        return a[ADDR_W-1:WIN_LSB] == base[ADDR_W-1:WIN_LSB];
    endfunction

    function automatic logic same_word(input addr_t a, input addr_t reg_addr);
        return a[ADDR_W-1:BYTE_W] == reg_addr[ADDR_W-1:BYTE_W];
    endfunction

    function automatic idx_t word_index(input addr_t a);
        return a[WIN_LSB-1:BYTE_W];
    endfunction

    function automatic word_t place_pend(input pend_t p);
        word_t w;
        w = '0;
        w[PEND_LSB +: MBX_N] = p;
        return w;
    endfunction

    function automatic pend_t take_pend(input word_t w);
        return w[PEND_LSB +: MBX_N];
    endfunction
endpackage

// File: rtl/mbx_host_dec.sv
module mbx_host_dec
    import mbx_pkg::*;
(
    input  addr_t addr,
    output hdec_t dec
);
    always_comb begin
        dec.idx = word_index(addr);
        if (same_word(addr, HST_STAT_ADDR)) begin
            dec.sel = HSEL_STAT;
        end else if (same_word(addr, HST_EN_ADDR)) begin
            dec.sel = HSEL_EN;
        end else if (in_window(addr, HST_MBX_BASE)) begin
            dec.sel = HSEL_MBX;
        end else begin
            dec.sel = HSEL_NONE;
        end
    end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  loc_wr,
    input  addr_t loc_addr,
    input  word_t loc_wdata,
    input  idx_t  rd_idx,
    output word_t rd_word,
    output pend_t set_pulse
);
    logic [MBX_N-1:0][DATA_W-1:0] mbx_q;
    logic loc_hit;
    idx_t loc_idx;

    assign loc_hit = loc_wr && in_window(loc_addr, LOC_MBX_BASE);
    assign loc_idx = word_index(loc_addr);

    for (genvar n = 0; n < MBX_N; n++) begin : g_slot
        logic slot_we;
        assign slot_we      = loc_hit && (loc_idx == idx_t'(n));
        assign set_pulse[n] = slot_we;

        always_ff @(posedge clk) begin
            if (rst) begin
                mbx_q[n] <= '0;
            end else if (slot_we) begin
                mbx_q[n] <= loc_wdata;
            end
        end
    end

    assign rd_word = mbx_q[rd_idx];

    // R1: a window write lands in the addressed slot
    a_r1_slot_written: assert property (@(posedge clk) disable iff (rst)
        loc_hit |=> mbx_q[$past(loc_idx)] == $past(loc_wdata));

    // R1/R2: nothing but a local window write moves mailbox contents
    a_r2_mbx_hold: assert property (@(posedge clk) disable iff (rst)
        !loc_hit |=> $stable(mbx_q));
endmodule

// File: rtl/mbx_irq_regs.sv
module mbx_irq_regs
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pend_t set_pulse,
    input  logic  clr_wr,
    input  pend_t clr_mask,
    input  logic  en_wr,
    input  pend_t en_val,
    output pend_t status,
    output pend_t enable,
    output logic  irq
);
    pend_t clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
            irq    <= 1'b0;
        end else begin
            irq    <= |(status & enable);
            status <= (status & ~clr_eff) | set_pulse;
            if (en_wr) begin
                enable <= en_val;
            end
        end
    end

    // R5: a set is never lost, even against a same-cycle clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_pulse) |=> ((status & $past(set_pulse)) == $past(set_pulse)));

    // R4: cleared bits without a competing set read zero afterwards
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((status & $past(clr_mask & ~set_pulse)) == '0));

    // R8: no enables means no interrupt in the next cycle
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |=> !irq);
endmodule

// File: rtl/mbx_dual_port.sv
module mbx_dual_port
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        loc_wr,
    input  logic [13:0] loc_addr,
    input  logic [31:0] loc_wdata,
    input  logic        hst_wr,
    input  logic        hst_rd,
    input  logic [13:0] hst_addr,
    input  logic [31:0] hst_wdata,
    output logic [31:0] hst_rdata,
    output logic        irq_out
);
    hdec_t hdec;
    word_t mbx_word;
    pend_t set_pulse;
    pend_t status;
    pend_t enable;
    word_t rd_next;

    mbx_host_dec u_dec (
        .addr (hst_addr),
        .dec  (hdec)
    );

    mbx_store u_store (
        .clk       (clk),
        .rst       (rst),
        .loc_wr    (loc_wr),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .rd_idx    (hdec.idx),
        .rd_word   (mbx_word),
        .set_pulse (set_pulse)
    );

    mbx_irq_regs u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (set_pulse),
        .clr_wr    (hst_wr && (hdec.sel == HSEL_STAT)),
        .clr_mask  (take_pend(hst_wdata)),
        .en_wr     (hst_wr && (hdec.sel == HSEL_EN)),
        .en_val    (take_pend(hst_wdata)),
        .status    (status),
        .enable    (enable),
        .irq       (irq_out)
    );

    always_comb begin
        unique case (hdec.sel)
            HSEL_STAT: rd_next = place_pend(status);
            HSEL_EN:   rd_next = place_pend(enable);
            HSEL_MBX:  rd_next = mbx_word;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_rdata <= '0;
        end else if (hst_rd) begin
            hst_rdata <= rd_next;
        end
    end

    // R6: reserved status bits return zero
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (hst_rd && hst_addr == HST_STAT_ADDR) |=> (hst_rdata[31:24] == '0 && hst_rdata[15:0] == '0));

    // R9: read data moves only on a read strobe
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !hst_rd |=> $stable(hst_rdata));

    // R10: reset leaves the host outputs at zero
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (hst_rdata == '0 && !irq_out));
endmodule

// File: tb/mbx_dual_port_tb_top.sv
module mbx_dual_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loc_wr = 1'b0;
    logic [13:0] loc_addr = '0;
    logic [31:0] loc_wdata = '0;
    logic        hst_wr = 1'b0;
    logic        hst_rd = 1'b0;
    logic [13:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model
    logic [31:0] m_mbx [8];
    logic [7:0]  m_st = '0;
    logic [7:0]  m_en = '0;
    logic        m_irq = 1'b0;
    logic [31:0] m_rd = '0;

    always #2 clk = ~clk;

    mbx_dual_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .loc_wr    (loc_wr),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .hst_wr    (hst_wr),
        .hst_rd    (hst_rd),
        .hst_addr  (hst_addr),
        .hst_wdata (hst_wdata),
        .hst_rdata (hst_rdata),
        .irq_out   (irq_out)
    );

    function automatic logic [31:0] exp_read(input logic [13:0] a);
        if (a[13:2] == 12'h010) return {8'h00, m_st, 16'h0000};
        if (a[13:2] == 12'h014) return {8'h00, m_en, 16'h0000};
        if (a[13:5] == 9'h048)  return m_mbx[a[4:2]];
        return 32'h0;
    endfunction

    function automatic string auto_tag(input logic [13:0] a);
        if (a[13:2] == 12'h010) return "R6";
        if (a[13:2] == 12'h014) return "R7";
        if (a[13:5] == 9'h048)  return "R2";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_mbx[i] = '0;
        m_st = '0; m_en = '0; m_irq = 1'b0; m_rd = '0;
    endtask

    task automatic cyc(input logic lw, input logic [13:0] la, input logic [31:0] ld,
                       input logic hw, input logic hr, input logic [13:0] ha,
                       input logic [31:0] hd, input string tag);
        logic [7:0] setv;
        @(negedge clk);
        loc_wr = lw; loc_addr = la; loc_wdata = ld;
        hst_wr = hw; hst_rd = hr; hst_addr = ha; hst_wdata = hd;
        @(posedge clk);
        if (hr) m_rd = exp_read(ha);
        m_irq = |(m_st & m_en);
        setv = '0;
        if (lw && la[13:5] == 9'h1D0) begin
            m_mbx[la[4:2]] = ld;
            setv[la[4:2]] = 1'b1;
        end
        if (hw && ha[13:2] == 12'h010) m_st = (m_st & ~hd[23:16]) | setv;
        else m_st = m_st | setv;
        if (hw && ha[13:2] == 12'h014) m_en = hd[23:16];
        #1;
        if (hr) check((tag == "") ? auto_tag(ha) : tag, hst_rdata, m_rd);
        check("R8", {31'h0, irq_out}, {31'h0, m_irq});
    endtask

    task automatic idle();
        cyc(1'b0, 14'h0, 32'h0, 1'b0, 1'b0, 14'h0, 32'h0, "");
    endtask

    task automatic hread(input logic [13:0] a, input string tag);
        cyc(1'b0, 14'h0, 32'h0, 1'b0, 1'b1, a, 32'h0, tag);
    endtask

    task automatic hwrite(input logic [13:0] a, input logic [31:0] d);
        cyc(1'b0, 14'h0, 32'h0, 1'b1, 1'b0, a, d, "");
    endtask

    task automatic lwrite(input logic [13:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 14'h0, 32'h0, "");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        loc_wr = 1'b0; hst_wr = 1'b0; hst_rd = 1'b0;
        @(posedge clk);
        model_reset();
        #1;
        check("R10", hst_rdata, 32'h0);
        check("R10", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [13:0] rand_addr();
        int unsigned k;
        k = $urandom_range(0, 5);
        case (k)
            0: return 14'h0040;
            1: return 14'h0050;
            2: return 14'h0900 + 14'($urandom_range(0, 7) * 4);
            3: return 14'h3A00 + 14'($urandom_range(0, 7) * 4);
            4: return 14'h0900 + 14'($urandom_range(0, 7) * 4);
            default: return 14'($urandom_range(0, 16383));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (2) @(posedge clk);
        do_reset();

        // R10: mailboxes and registers empty after reset
        for (int i = 0; i < 8; i++) hread(14'h0900 + 14'(i * 4), "R10");
        hread(14'h0040, "R10");
        hread(14'h0050, "R10");

        // R1 / R3: write mailbox 7, then 6
        lwrite(14'h3A1C, 32'hCAFE_0007);
        hread(14'h091C, "R1");
        hread(14'h0040, "R3");
        lwrite(14'h3A18, 32'h1234_5678);
        hread(14'h0918, "R1");
        hread(14'h0040, "R3");

        // R1: writes outside the local window touch nothing
        lwrite(14'h3A20, 32'hDEAD_BEEF);
        lwrite(14'h0900, 32'hDEAD_BEEF);
        for (int i = 0; i < 8; i++) hread(14'h0900 + 14'(i * 4), "R1");
        hread(14'h0040, "R1");

        // R2: host writes into the read window are ignored
        hwrite(14'h091C, 32'h0);
        hread(14'h091C, "R2");

        // R4: writing 0 keeps, writing 1 clears
        hwrite(14'h0040, 32'h0000_0000);
        hread(14'h0040, "R4");
        hwrite(14'h0040, 32'h0080_0000);
        hread(14'h0040, "R4");

        // R5: same-cycle set and clear of bit 22
        cyc(1'b1, 14'h3A18, 32'h0000_0066, 1'b1, 1'b0, 14'h0040, 32'h0040_0000, "");
        hread(14'h0040, "R5");

        // R7 / R8: enables and interrupt timing
        hwrite(14'h0050, 32'hFFFF_FFFF);
        hread(14'h0050, "R7");
        idle();
        hwrite(14'h0050, 32'h0);
        idle();
        idle();
        hwrite(14'h0050, 32'h0040_0000);
        idle();
        hwrite(14'h0040, 32'h00FF_0000);
        idle();
        idle();

        // R6 / R9: reserved bits, undefined offsets, hold without strobe
        lwrite(14'h3A00, 32'h0BAD_F00D);
        hread(14'h0040, "R6");
        hread(14'h0044, "R9");
        hread(14'h3A00, "R9");
        hread(14'h0000, "R9");
        idle();
        check("R9", hst_rdata, 32'h0);

        // constrained random mix
        for (int t = 0; t < 3000; t++) begin
            cyc(($urandom_range(0, 2) == 0), rand_addr(), $urandom(),
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 0), rand_addr(),
                (($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : $urandom()), "");
        end

        // R10: reset in the middle of activity
        hwrite(14'h0050, 32'h00FF_0000);
        lwrite(14'h3A04, 32'h5555_AAAA);
        do_reset();
        hread(14'h0904, "R10");
        hread(14'h0040, "R10");
        hread(14'h0050, "R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule